// File: doc/BRIEF.md
# Offset Divide-by-N Feedback Counter

This block divides the oscillator-derived feedback clock by a programmable ratio. A 14-bit divide value is combined with a select input. When the select is low, a fixed intermediate-frequency offset (856 by default) is added, so a transceiver can shift its oscillator between transmit and receive without rewriting the divide value. When the select is high, the divide value is used unchanged. The adder result is registered and used as the preset of a down counter. Each time the counter reaches zero, it reloads and the block gives one single-cycle output pulse. These pulses are the divided feedback signal that a phase detector compares with the reference.

The sum wraps modulo 2^14. Any ratio below 3 is raised to 3, so the output period stays defined. In a typical system the select input has a board pull-up, so an unconnected select means no offset. The RTL does not model the pull-up; it only sees a logic 1.

Top module: `divn_offset_divider`

## Requirements
- R1: While `rst` is high, `fv_pulse` is 0. On the first rising clock edge after `rst` goes low, `fv_pulse` goes high.
- R2: With `offset_off` = 1, the distance between consecutive rising edges of `fv_pulse` is `div_value` clock cycles, for any `div_value` from 3 to 16383.
- R3: With `offset_off` = 0, the distance between consecutive rising edges of `fv_pulse` is `div_value` + 856 clock cycles, when that sum is below 16384.
- R4: The offset sum is taken modulo 16384. For example, `div_value` = 16000 with the offset gives a period of 472.
- R5: When the effective ratio (after the offset and the wrap) is 0, 1 or 2, the period is 3 clock cycles. A ratio of exactly 3 also gives 3.
- R6: Each `fv_pulse` is high for exactly one clock cycle.
- R7: A change of `div_value` or `offset_off` sets the period no later than the interval that starts at the second `fv_pulse` after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Feedback clock derived from the oscillator |
| rst | input | 1 | Synchronous active-high reset |
| div_value | input | 14 | Programmed divide value, bit 0 least significant |
| offset_off | input | 1 | 1: no offset; 0: add the fixed offset |
| fv_pulse | output | 1 | Registered one-cycle pulse per completed count |

## Verification
Small, medium and large divide values are applied with the offset disabled. These show whether the counter divides by the programmed value, with no off-by-one at either end of the 14-bit range. The same values are repeated with the offset enabled, which shows that the offset is added and applied with the correct sense of the select. Sums that cross 16384 show that the wrap is handled. Values that land on 0, 2 and 3 tell the clamp apart from a plain reload. A change of ratio between runs, and a reset asserted in the middle of a count, show when a new ratio takes effect and how the output restarts.

// File: rtl/divn_pkg.sv
package divn_pkg;
  // Default geometry of the feedback divider
  localparam int unsigned DIVN_WIDTH      = 14;
  localparam int unsigned DIVN_IF_OFFSET  = 856;
  localparam int unsigned DIVN_MIN_RATIO  = 3;
endpackage

// File: rtl/divn_ratio_calc.sv
// Adds the optional fixed offset, wraps, clamps and registers the reload value.
module divn_ratio_calc #(
  parameter int unsigned W       = divn_pkg::DIVN_WIDTH,
  parameter int unsigned OFFSET  = divn_pkg::DIVN_IF_OFFSET,
  parameter int unsigned MIN_DIV = divn_pkg::DIVN_MIN_RATIO
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] div_value,
  input  logic         offset_off,
  output logic [W-1:0] load_q
);
  localparam logic [W-1:0] OFF_W = W'(OFFSET);
  localparam logic [W-1:0] MIN_W = W'(MIN_DIV);
  localparam logic [W-1:0] ONE_W = W'(1);

  logic [W-1:0] sum;
  logic [W-1:0] ratio;

  always_comb begin
    // W-bit addition wraps modulo 2^W
    sum   = offset_off ? div_value : (div_value + OFF_W);
    ratio = (sum < MIN_W) ? MIN_W : sum;
  end

  // Store ratio-1 so the counter reloads without an extra subtract
  always_ff @(posedge clk) begin
    if (rst) load_q <= MIN_W - ONE_W;
    else     load_q <= ratio - ONE_W;
  end
endmodule

// File: rtl/divn_down_counter.sv
// Down counter with reload at zero and a registered single-cycle pulse.
module divn_down_counter #(
  parameter int unsigned W       = divn_pkg::DIVN_WIDTH,
  parameter int unsigned MIN_DIV = divn_pkg::DIVN_MIN_RATIO
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] load_val,
  output logic         fv_q
);
  localparam logic [W-1:0] ONE_W   = W'(1);
  localparam logic [W-1:0] FLOOR_W = W'(MIN_DIV - 1);

  logic [W-1:0] count;
  logic         at_zero;

  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      fv_q  <= 1'b0;
    end else begin
      fv_q <= at_zero;
      if (at_zero) count <= load_val;
      else         count <= count - ONE_W;
    end
  end

  // R6: pulse never lasts two cycles
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    fv_q |=> !fv_q);

  // R2: at zero the counter takes the value offered by the ratio stage
  p_reload_r2: assert property (@(posedge clk) disable iff (rst)
    at_zero |=> (count == $past(load_val)));

  // R2: otherwise it steps down by one
  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    !at_zero |=> (count == $past(count) - ONE_W));

  // R5: ratio stage never offers a reload below the floor
  p_load_floor_r5: assert property (@(posedge clk) disable iff (rst)
    load_val >= FLOOR_W);
endmodule

// File: rtl/divn_offset_divider.sv
// Top: programmable feedback divider with optional fixed offset.
module divn_offset_divider #(
  parameter int unsigned W       = divn_pkg::DIVN_WIDTH,
  parameter int unsigned OFFSET  = divn_pkg::DIVN_IF_OFFSET,
  parameter int unsigned MIN_DIV = divn_pkg::DIVN_MIN_RATIO
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] div_value,
  input  logic         offset_off,
  output logic         fv_pulse
);
  logic [W-1:0] load_val;

  divn_ratio_calc #(.W(W), .OFFSET(OFFSET), .MIN_DIV(MIN_DIV)) u_ratio (
    .clk        (clk),
    .rst        (rst),
    .div_value  (div_value),
    .offset_off (offset_off),
    .load_q     (load_val)
  );

  divn_down_counter #(.W(W), .MIN_DIV(MIN_DIV)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load_val (load_val),
    .fv_q     (fv_pulse)
  );

  // R1: output is quiet in the cycle after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !fv_pulse);
endmodule

// File: tb/divn_offset_divider_test.sv
module divn_offset_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] div_value = 14'd5;
  logic        offset_off = 1'b1;
  logic        fv_pulse;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  divn_offset_divider uut (
    .clk        (clk),
    .rst        (rst),
    .div_value  (div_value),
    .offset_off (offset_off),
    .fv_pulse   (fv_pulse)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected at most 190000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  // advance to a negedge where fv_pulse has just gone high
  task automatic next_rise();
    bit prev;
    prev = fv_pulse;
    @(negedge clk);
    while (!(fv_pulse && !prev)) begin
      prev = fv_pulse;
      @(negedge clk);
    end
  endtask

  // called at a rise: measure high width and rise-to-rise period
  task automatic measure(output int per, output int wid);
    per = 0;
    wid = 0;
    while (fv_pulse) begin
      wid++;
      per++;
      @(negedge clk);
    end
    while (!fv_pulse) begin
      per++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(string req, int n, bit off, int exp_per);
    int per;
    int wid;
    @(negedge clk);
    div_value  = 14'(n);
    offset_off = off;
    next_rise();
    next_rise();
    measure(per, wid);
    check(req, per, exp_per);
    check("R6 width", wid, 1);
  endtask

  task automatic test_reset();
    int seen;
    seen = 0;
    rst = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (fv_pulse) seen++;
    end
    check("R1 quiet in reset", seen, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first pulse after release", int'(fv_pulse), 1);
  endtask

  task automatic test_mid_reset();
    int seen;
    seen = 0;
    @(negedge clk);
    div_value  = 14'd40;
    offset_off = 1'b1;
    next_rise();
    repeat (7) @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (fv_pulse) seen++;
    end
    check("R1 quiet in mid-run reset", seen, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 restart pulse", int'(fv_pulse), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    // R2 no offset
    run_case("R2 n=5", 5, 1'b1, 5);
    run_case("R2 n=100", 100, 1'b1, 100);
    run_case("R2 n=4000", 4000, 1'b1, 4000);
    // R3 offset added when select low
    run_case("R3 n=5", 5, 1'b0, 861);
    run_case("R3 n=1000", 1000, 1'b0, 1856);
    // R4 wrap modulo 16384
    run_case("R4 n=16000", 16000, 1'b0, 472);
    run_case("R4 n=16383", 16383, 1'b0, 855);
    // R5 clamp
    run_case("R5 n=0", 0, 1'b1, 3);
    run_case("R5 n=2", 2, 1'b1, 3);
    run_case("R5 n=3", 3, 1'b1, 3);
    run_case("R5 wrap to 0", 15528, 1'b0, 3);
    run_case("R5 wrap to 2", 15530, 1'b0, 3);
    // R7 change applies by the second pulse
    run_case("R7 switch to 9", 9, 1'b1, 9);
    run_case("R7 select low", 9, 1'b0, 865);
    // R2 top of range
    run_case("R2 n=16383", 16383, 1'b1, 16383);
    test_mid_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule